// File: doc/BRIEF.md
# Instruction Prefetch Buffer with Flush

This block keeps up to eight sequential 32-bit instruction words queued ahead of the script execution engine. Whenever the queue has room and no memory read is pending, it reads the next sequential word over a simple request/response port. The decoder reads the word at the head of the queue and pops it with a one-cycle consume strobe.

The queue is emptied whenever its contents may no longer be the instructions that run next. This happens on a store instruction, unless the store carries a no-flush qualifier. It also happens on a software write to the script pointer, on a transfer-control instruction whose condition is met, and when software sets a self-clearing flush bit in an 8-bit control register. After a flush, fetching restarts at the right address: the written pointer value, the transfer target, or the address of the current head word. A read that is still in flight when the flush happens is dropped when it returns.

Top module: `prefetch_buffer`

## Requirements
- R1: After reset the queue is empty (`empty_o`=1, `instr_valid_o`=0), the control readback is 0, and a fetch request is raised at address `RESET_ADDR` (default 0).
- R2: A request is raised only when the queue has a free slot and no read is pending. At most one read is outstanding. Each accepted request advances the fetch address by 4 bytes.
- R3: The queue holds at most `DEPTH` (8) words. A full queue raises no request.
- R4: Words leave the queue in the order of their addresses. `instr_data_o` always shows the oldest word.
- R5: A store with `store_no_flush_i`=0 flushes the queue, and refill restarts at the address of the current head word. A store with `store_no_flush_i`=1 leaves the queue untouched.
- R6: A write to the script pointer flushes the queue, and the next request uses the written address.
- R7: A transfer-control instruction flushes the queue and restarts at its target only when `xfer_taken_i`=1. A not-taken transfer has no effect.
- R8: Writing 1 to bit 6 of the control register sets the flush bit. The bit reads back 1 for one cycle. The flush is performed on the following edge, and the bit then reads back 0.
- R9: A read response whose request was issued before a flush is discarded and never enters the queue.
- R10: When a flush and a consume happen in the same cycle, the flush wins. The queue becomes empty and the consume does not advance the head address.
- R11: If several triggers coincide, the restart address is chosen in this order: pointer write first, then taken transfer target, then current head address.
- R12: No request is raised in a cycle in which a flush is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_o | output | 1 | Fetch request |
| req_addr_o | output | AW | Byte address of requested word |
| req_ready_i | input | 1 | Memory accepts the request |
| rsp_valid_i | input | 1 | Read response strobe |
| rsp_data_i | input | DW | Read response word |
| instr_valid_o | output | 1 | Head word is present |
| instr_data_o | output | DW | Head word |
| empty_o | output | 1 | Queue empty |
| consume_i | input | 1 | Pop head word |
| store_exec_i | input | 1 | Store instruction executed |
| store_no_flush_i | input | 1 | Store carries no-flush qualifier |
| ptr_wr_i | input | 1 | Script pointer write |
| ptr_data_i | input | AW | New script pointer value |
| xfer_valid_i | input | 1 | Transfer-control instruction executed |
| xfer_taken_i | input | 1 | Transfer condition met |
| xfer_target_i | input | AW | Transfer target address |
| ctl_wr_i | input | 1 | Control register write |
| ctl_wdata_i | input | 8 | Control register write data |
| ctl_rdata_o | output | 8 | Control register readback |

## Verification
The bench aims at the flush cases that a plain queue would get wrong.

- **Flush and consume together.** A design that let the consume win would refill from one word past the head.
- **Coinciding triggers.** A wrong priority would refill from the transfer target or the head instead of the written pointer.
- **Flush while a read is outstanding.** Without the discard, a stale word from the old stream would appear at the head.
- **The self-clearing bit.** It must read 1 for exactly one cycle before the flush takes effect. A design that held it set would keep the queue empty.

Non-flushing stores and not-taken transfers are followed by a check that the head word is unchanged.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic [1:0] {RST_HEAD, RST_JUMP, RST_PTR} restart_src_e;
  localparam int unsigned DWORD_BYTES = 4;
endpackage

// File: rtl/pf_queue.sv
module pf_queue #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 32,
  localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic [CW-1:0] count_o
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [IW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_pop;

  assign do_pop  = pop_i && (cnt_q != '0);
  assign data_o  = mem_q[rd_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_i && !clear_i) mem_q[wr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (do_pop) rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      unique case ({push_i, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (count_o != FULL));
  p_clear_empties_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (count_o == '0));
endmodule

// File: rtl/pf_flush_ctl.sv
module pf_flush_ctl
  import pf_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned CTL_W     = 8,
  parameter int unsigned FLUSH_BIT = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             store_exec_i,
  input  logic             store_no_flush_i,
  input  logic             ptr_wr_i,
  input  logic [AW-1:0]    ptr_data_i,
  input  logic             xfer_valid_i,
  input  logic             xfer_taken_i,
  input  logic [AW-1:0]    xfer_target_i,
  input  logic             ctl_wr_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  input  logic [AW-1:0]    head_addr_i,
  output logic             flush_o,
  output logic [AW-1:0]    restart_addr_o,
  output logic [CTL_W-1:0] ctl_rdata_o
);
  logic         bit_q;
  logic         jump;
  restart_src_e src;
  logic         unused_wdata;

  assign unused_wdata = ^ctl_wdata_i;
  assign jump         = xfer_valid_i && xfer_taken_i;

  // set by software, dropped on the edge that performs the flush
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bit_q <= 1'b0;
    else         bit_q <= ctl_wr_i && ctl_wdata_i[FLUSH_BIT];
  end

  assign flush_o = (store_exec_i && !store_no_flush_i) || ptr_wr_i || jump || bit_q;

  always_comb begin
    if (ptr_wr_i)  src = RST_PTR;
    else if (jump) src = RST_JUMP;
    else           src = RST_HEAD;
  end

  always_comb begin
    unique case (src)
      RST_PTR:  restart_addr_o = ptr_data_i;
      RST_JUMP: restart_addr_o = xfer_target_i;
      default:  restart_addr_o = head_addr_i;
    endcase
  end

  always_comb begin
    ctl_rdata_o            = '0;
    ctl_rdata_o[FLUSH_BIT] = bit_q;
  end

  p_ctl_flush_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr_i && ctl_wdata_i[FLUSH_BIT]) |=> flush_o);
  p_selfclear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_rdata_o[FLUSH_BIT] && !ctl_wr_i) |=> !ctl_rdata_o[FLUSH_BIT]);
  p_nf_store_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_exec_i && store_no_flush_i && !ptr_wr_i && !jump && !ctl_rdata_o[FLUSH_BIT])
      |-> !flush_o);
endmodule

// File: rtl/pf_fetch_seq.sv
module pf_fetch_seq
  import pf_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned DEPTH      = 8,
  parameter logic [AW-1:0] RESET_ADDR = '0,
  localparam int unsigned CW        = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic [AW-1:0] restart_addr_i,
  input  logic [CW-1:0] q_count_i,
  input  logic          pop_i,
  input  logic          req_ready_i,
  input  logic          rsp_valid_i,
  output logic          req_valid_o,
  output logic [AW-1:0] req_addr_o,
  output logic          push_o,
  output logic [AW-1:0] head_addr_o
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [AW-1:0] STEP = AW'(DWORD_BYTES);

  logic [AW-1:0] fetch_q, head_q;
  logic          pend_q, drop_q;
  logic          accept, rsp_hit;

  assign req_valid_o = !pend_q && (q_count_i < FULL) && !flush_i;
  assign req_addr_o  = fetch_q;
  assign head_addr_o = head_q;
  assign accept      = req_valid_o && req_ready_i;
  assign rsp_hit     = pend_q && rsp_valid_i;
  assign push_o      = rsp_hit && !drop_q && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fetch_q <= RESET_ADDR;
      head_q  <= RESET_ADDR;
      pend_q  <= 1'b0;
      drop_q  <= 1'b0;
    end else if (flush_i) begin
      fetch_q <= restart_addr_i;
      head_q  <= restart_addr_i;
      // a read still in flight must be swallowed when it returns
      pend_q  <= pend_q && !rsp_valid_i;
      drop_q  <= pend_q && !rsp_valid_i;
    end else begin
      if (accept) begin
        fetch_q <= fetch_q + STEP;
        pend_q  <= 1'b1;
      end else if (rsp_hit) begin
        pend_q  <= 1'b0;
        drop_q  <= 1'b0;
      end
      if (pop_i) head_q <= head_q + STEP;
    end
  end

  p_one_outstanding_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_ready_i) |=> !req_valid_o);
  p_no_req_full_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_count_i == FULL) |-> !req_valid_o);
  p_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (req_addr_o == $past(restart_addr_i)));
  p_discard_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_q && rsp_valid_i) |-> !push_o);
endmodule

// File: rtl/prefetch_buffer.sv
module prefetch_buffer #(
  parameter int unsigned   AW         = 32,
  parameter int unsigned   DW         = 32,
  parameter int unsigned   DEPTH      = 8,
  parameter int unsigned   FLUSH_BIT  = 6,
  parameter logic [AW-1:0] RESET_ADDR = '0,
  localparam int unsigned  CTL_W      = 8,
  localparam int unsigned  CW         = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             req_valid_o,
  output logic [AW-1:0]    req_addr_o,
  input  logic             req_ready_i,
  input  logic             rsp_valid_i,
  input  logic [DW-1:0]    rsp_data_i,
  output logic             instr_valid_o,
  output logic [DW-1:0]    instr_data_o,
  output logic             empty_o,
  input  logic             consume_i,
  input  logic             store_exec_i,
  input  logic             store_no_flush_i,
  input  logic             ptr_wr_i,
  input  logic [AW-1:0]    ptr_data_i,
  input  logic             xfer_valid_i,
  input  logic             xfer_taken_i,
  input  logic [AW-1:0]    xfer_target_i,
  input  logic             ctl_wr_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  output logic [CTL_W-1:0] ctl_rdata_o
);
  logic          flush, push, pop;
  logic [AW-1:0] restart_addr, head_addr;
  logic [CW-1:0] count;

  assign empty_o       = (count == '0);
  assign instr_valid_o = !empty_o;
  assign pop           = consume_i && instr_valid_o && !flush;

  pf_flush_ctl #(.AW(AW), .CTL_W(CTL_W), .FLUSH_BIT(FLUSH_BIT)) u_flush (
    .clk_i, .rst_ni,
    .store_exec_i, .store_no_flush_i,
    .ptr_wr_i, .ptr_data_i,
    .xfer_valid_i, .xfer_taken_i, .xfer_target_i,
    .ctl_wr_i, .ctl_wdata_i,
    .head_addr_i    (head_addr),
    .flush_o        (flush),
    .restart_addr_o (restart_addr),
    .ctl_rdata_o
  );

  pf_fetch_seq #(.AW(AW), .DEPTH(DEPTH), .RESET_ADDR(RESET_ADDR)) u_fetch (
    .clk_i, .rst_ni,
    .flush_i        (flush),
    .restart_addr_i (restart_addr),
    .q_count_i      (count),
    .pop_i          (pop),
    .req_ready_i, .rsp_valid_i,
    .req_valid_o, .req_addr_o,
    .push_o         (push),
    .head_addr_o    (head_addr)
  );

  pf_queue #(.DEPTH(DEPTH), .DW(DW)) u_queue (
    .clk_i, .rst_ni,
    .clear_i     (flush),
    .push_i      (push),
    .push_data_i (rsp_data_i),
    .pop_i       (pop),
    .data_o      (instr_data_o),
    .count_o     (count)
  );

  p_flush_beats_consume_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush && consume_i) |=> empty_o);
  p_no_req_on_flush_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_wr_i |-> !req_valid_o);
endmodule

// File: tb/prefetch_buffer_test.sv
module prefetch_buffer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;

  typedef struct packed {
    logic [3:0]  nc;
    logic [2:0]  kind;
    logic [15:0] arg;
    logic [15:0] exp;
    logic        fl;
  } vec_t;

  // kind: 0 store flush, 1 store no-flush, 2 ptr write, 3 xfer not taken, 4 xfer taken, 5 ctl bit
  localparam vec_t VEC [NV] = '{
    '{4'd2, 3'd0, 16'h0000, 16'h0088, 1'b1},
    '{4'd0, 3'd1, 16'h0000, 16'h0088, 1'b0},
    '{4'd1, 3'd2, 16'h0100, 16'h0100, 1'b1},
    '{4'd3, 3'd3, 16'h0300, 16'h010C, 1'b0},
    '{4'd0, 3'd4, 16'h0200, 16'h0200, 1'b1},
    '{4'd1, 3'd5, 16'h0000, 16'h0204, 1'b1},
    '{4'd2, 3'd2, 16'h0040, 16'h0040, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid, req_ready;
  logic [31:0] req_addr;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        instr_valid, empty;
  logic [31:0] instr_data;
  logic        consume, store_exec, store_nf, ptr_wr, xfer_valid, xfer_taken, ctl_wr;
  logic [31:0] ptr_data, xfer_target;
  logic [7:0]  ctl_wdata, ctl_rdata;

  int  errors = 0;
  int  checks = 0;
  int  mem_lat = 0;
  bit  done = 1'b0;
  logic        mem_pend;
  int          mem_cnt;
  logic [31:0] mem_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  prefetch_buffer uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_o(req_valid), .req_addr_o(req_addr), .req_ready_i(req_ready),
    .rsp_valid_i(rsp_valid), .rsp_data_i(rsp_data),
    .instr_valid_o(instr_valid), .instr_data_o(instr_data), .empty_o(empty),
    .consume_i(consume), .store_exec_i(store_exec), .store_no_flush_i(store_nf),
    .ptr_wr_i(ptr_wr), .ptr_data_i(ptr_data),
    .xfer_valid_i(xfer_valid), .xfer_taken_i(xfer_taken), .xfer_target_i(xfer_target),
    .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata), .ctl_rdata_o(ctl_rdata)
  );

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return {16'hA5A5, a[15:0]};
  endfunction

  // memory model: responds mem_lat+1 cycles after accepting a request
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_pend  <= 1'b0;
      mem_cnt   <= 0;
      mem_addr  <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (req_valid && req_ready) begin
        mem_pend <= 1'b1;
        mem_addr <= req_addr;
        mem_cnt  <= mem_lat;
      end else if (mem_pend) begin
        if (mem_cnt == 0) begin
          rsp_valid <= 1'b1;
          rsp_data  <= word_at(mem_addr);
          mem_pend  <= 1'b0;
        end else begin
          mem_cnt <= mem_cnt - 1;
        end
      end
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pop_n(input int n);
    for (int i = 0; i < n; i++) begin
      consume = 1'b1;
      @(negedge clk);
      consume = 1'b0;
    end
  endtask

  task automatic drive(input logic [2:0] kind, input logic [31:0] arg);
    case (kind)
      3'd0: store_exec = 1'b1;
      3'd1: begin store_exec = 1'b1; store_nf = 1'b1; end
      3'd2: begin ptr_wr = 1'b1; ptr_data = arg; end
      3'd3: begin xfer_valid = 1'b1; xfer_target = arg; end
      3'd4: begin xfer_valid = 1'b1; xfer_taken = 1'b1; xfer_target = arg; end
      default: begin ctl_wr = 1'b1; ctl_wdata = 8'h40; end
    endcase
  endtask

  task automatic idle();
    store_exec = 1'b0; store_nf = 1'b0; ptr_wr = 1'b0; xfer_valid = 1'b0;
    xfer_taken = 1'b0; ctl_wr = 1'b0; ctl_wdata = '0;
  endtask

  function automatic string tag(input logic [2:0] kind);
    case (kind)
      3'd0, 3'd1: return "R5";
      3'd2:       return "R6";
      3'd3, 3'd4: return "R7";
      default:    return "R8";
    endcase
  endfunction

  initial begin
    req_ready = 1'b1; consume = 1'b0; ptr_data = '0; xfer_target = '0;
    idle();
    cyc(3);
    rst_n = 1'b1;
    #1;
    chk("R1 empty", 32'(empty), 32'd1);
    chk("R1 valid", 32'(instr_valid), 32'd0);
    chk("R1 req", 32'(req_valid), 32'd1);
    chk("R1 addr", req_addr, 32'h0);
    chk("R1 ctl", 32'(ctl_rdata), 32'h0);

    // R12: pointer write blocks the request in the flush cycle
    ptr_wr = 1'b1; ptr_data = 32'h80;
    #1 chk("R12 no req during flush", 32'(req_valid), 32'd0);
    @(negedge clk); idle();
    #1;
    chk("R6 req addr", req_addr, 32'h80);
    chk("R6 empty", 32'(empty), 32'd1);
    @(negedge clk); #1 chk("R2 one outstanding a", 32'(req_valid), 32'd0);
    @(negedge clk); #1 chk("R2 one outstanding b", 32'(req_valid), 32'd0);
    @(negedge clk); #1;
    chk("R2 next addr", req_addr, 32'h84);
    chk("R2 first word", instr_data, word_at(32'h80));
    cyc(40); #1;
    chk("R3 full no req", 32'(req_valid), 32'd0);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      pop_n(int'(VEC[v].nc));
      drive(VEC[v].kind, {16'h0, VEC[v].arg});
      @(negedge clk);
      idle();
      if (VEC[v].kind == 3'd5) begin
        #1 chk("R8 bit reads 1", 32'(ctl_rdata), 32'h40);
        @(negedge clk);
        #1 chk("R8 bit cleared", 32'(ctl_rdata), 32'h0);
      end
      #1 chk({tag(VEC[v].kind), " flush state"}, 32'(empty), 32'(VEC[v].fl));
      cyc(40); #1;
      chk({tag(VEC[v].kind), " head"}, instr_data, word_at({16'h0, VEC[v].exp}));
    end

    // R4: in-order delivery across back-to-back pops
    for (int i = 0; i < 8; i++) begin
      #1;
      chk("R4 order", instr_data, word_at(32'h40 + 32'(4*i)));
      consume = 1'b1;
      @(negedge clk);
      consume = 1'b0;
    end
    cyc(40);

    // R10: flush and consume together, head 0x60
    consume = 1'b1; store_exec = 1'b1;
    @(negedge clk); consume = 1'b0; idle();
    #1 chk("R10 empty", 32'(empty), 32'd1);
    cyc(40); #1 chk("R10 restart at unconsumed head", instr_data, word_at(32'h60));

    // R11: priority of coincident triggers
    ptr_wr = 1'b1; ptr_data = 32'h700; xfer_valid = 1'b1; xfer_taken = 1'b1; xfer_target = 32'h900;
    @(negedge clk); idle();
    cyc(40); #1 chk("R11 ptr over jump", instr_data, word_at(32'h700));
    xfer_valid = 1'b1; xfer_taken = 1'b1; xfer_target = 32'h900; store_exec = 1'b1;
    @(negedge clk); idle();
    cyc(40); #1 chk("R11 jump over head", instr_data, word_at(32'h900));

    // R9: flush while a read is in flight
    mem_lat = 6;
    pop_n(1);
    @(negedge clk);
    ptr_wr = 1'b1; ptr_data = 32'h500;
    @(negedge clk); idle();
    mem_lat = 0;
    #1 chk("R9 empty after flush", 32'(empty), 32'd1);
    chk("R9 waits for stale read", 32'(req_valid), 32'd0);
    cyc(60); #1;
    chk("R9 stale word dropped", instr_data, word_at(32'h500));
    pop_n(1); #1;
    chk("R9 sequence", instr_data, word_at(32'h504));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule